// File: doc/BRIEF.md
# Option-Configurable Watchdog Timer

This block guards a small processor core against runaway code. It counts ticks from one of two sources, either strobes from a dedicated free-running oscillator or an instruction-rate tick made by dividing the core clock by four. The ticks pass through an 8-bit prescaler, a 7-bit ripple stage with four selectable taps and a final divide-by-two. When the chain wraps, the block issues one of two reset requests. A chip-wide reset goes out while the core is running. A warm reset, which clears only the program counter and stack pointer, goes out while the core sits in its halted state.

Static strap inputs set the block up. They choose the tick source, the tap, whether the watchdog is active, and whether software must issue one clear command or a pair of distinct ones. Whatever the strap setting, the count also restarts when the core executes its halt instruction. A sticky time-out flag records that a chip reset came from the watchdog. Only the external reset or a dedicated status-clear strobe clears that flag. Everything runs in the `clk_i` domain. The dedicated oscillator arrives as a synchronised one-cycle enable strobe.

Top module: `opt_wdt`

## Requirements
- R1: With a tick on every counted cycle, a reset request occurs after exactly 2^(13+tap_sel_i) ticks from a cleared count. The encodings are tap_sel_i 0 = 8192, 1 = 16384, 2 = 32768 and 3 = 65536 ticks.
- R2: src_sel_i = 0 counts osc_tick_i strobes. src_sel_i = 1 counts one tick every 4 clk_i cycles while the core is not halted.
- R3: With src_sel_i = 1, no ticks are counted while halted_i = 1. Counting resumes from the same state when halted_i returns to 0.
- R4: Overflow with halted_i = 0 drives chip_rst_o high for exactly one clk_i cycle, starting in the cycle after the clock edge of the overflowing tick, and sets to_o.
- R5: Overflow with halted_i = 1 drives warm_rst_o high for one cycle instead. chip_rst_o stays low and to_o is unchanged. The two pulses never coincide.
- R6: With dual_clr_i = 0, a clr_i strobe restarts the count. clr1_i and clr2_i have no effect.
- R7: With dual_clr_i = 1, the count restarts on the cycle in which both clr1_i and clr2_i have been seen since the last restart, in either order. Repeating one of them does not restart the count, and clr_i has no effect. An overflow also forgets any command seen so far.
- R8: A halt_cmd_i strobe restarts the count in either clear mode.
- R9: A clear on the same cycle as an overflowing tick wins. No reset pulse is issued and the count restarts from zero.
- R10: With wdt_en_i = 0, the count is held at zero, neither reset pulse is issued and to_o is not set.
- R11: to_o stays set until rst_ni is low or a to_clr_i strobe arrives.
- R12: While rst_ni is low, chip_rst_o, warm_rst_o and to_o are low, and the count restarts from zero on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | External reset, active low, asynchronous |
| src_sel_i | input | 1 | Tick source: 0 dedicated oscillator, 1 core clock divided by 4 |
| osc_tick_i | input | 1 | One-cycle strobe per dedicated-oscillator period |
| tap_sel_i | input | 2 | Division tap, time-out 2^(13+tap_sel_i) ticks |
| wdt_en_i | input | 1 | Watchdog enable strap |
| dual_clr_i | input | 1 | 0: one clear command, 1: pair of clear commands |
| clr_i | input | 1 | Single-mode clear strobe |
| clr1_i | input | 1 | First clear command of the pair |
| clr2_i | input | 1 | Second clear command of the pair |
| halt_cmd_i | input | 1 | Strobe when the halt instruction executes |
| halted_i | input | 1 | Core is in the halted state |
| to_clr_i | input | 1 | Clears the time-out flag |
| chip_rst_o | output | 1 | One-cycle chip reset request |
| warm_rst_o | output | 1 | One-cycle warm reset request |
| to_o | output | 1 | Sticky time-out flag |

## Verification
The count and the pair-command flags cannot be seen from outside. A wrong value in either one only shows up as a reset pulse on the wrong cycle. So every case measures the exact cycle of the pulse against a cleared count: one edge early or late points to a wrong tap, a missed clear or a stale flag. A flag that survives an overflow moves the next pulse by one edge, and the bench sits on that edge. A frozen or free-running instruction divider during halt shifts the pulse by thousands of cycles, which the halted-interval case catches at its single expected edge.

// File: rtl/opt_wdt_pkg.sv
package opt_wdt_pkg;
  typedef enum logic {
    SRC_OSC  = 1'b0,
    SRC_INST = 1'b1
  } wdt_src_e;

  typedef enum logic {
    CLR_ONE = 1'b0,
    CLR_TWO = 1'b1
  } wdt_clr_mode_e;
endpackage

// File: rtl/opt_wdt_tick_sel.sv
module opt_wdt_tick_sel
  import opt_wdt_pkg::*;
#(
  parameter int INST_DIV = 4,
  localparam int DIV_W = $clog2(INST_DIV)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wdt_src_e src_i,
  input  logic     osc_tick_i,
  input  logic     halted_i,
  output logic     tick_o
);
  logic [DIV_W-1:0] div_q;
  logic             inst_tick;

  // core clock is stopped in halt: divider freezes
  assign inst_tick = ~halted_i & (div_q == DIV_W'(INST_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (!halted_i) div_q <= inst_tick ? '0 : div_q + 1'b1;
  end

  assign tick_o = (src_i == SRC_INST) ? inst_tick : osc_tick_i;
endmodule

// File: rtl/opt_wdt_clr_ctl.sv
module opt_wdt_clr_ctl
  import opt_wdt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  wdt_clr_mode_e mode_i,
  input  logic          clr_i,
  input  logic          clr1_i,
  input  logic          clr2_i,
  input  logic          halt_cmd_i,
  input  logic          ovf_i,
  output logic          clr_o
);
  logic seen1_q, seen2_q;
  logic pair_done;

  assign pair_done = (seen1_q | clr1_i) & (seen2_q | clr2_i);

  always_comb begin
    clr_o = halt_cmd_i;
    if (mode_i == CLR_ONE) clr_o = clr_o | clr_i;
    else                   clr_o = clr_o | pair_done;
    clr_o = clr_o & en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen1_q <= 1'b0;
      seen2_q <= 1'b0;
    end else if (!en_i || clr_o || ovf_i || mode_i == CLR_ONE) begin
      seen1_q <= 1'b0;
      seen2_q <= 1'b0;
    end else begin
      seen1_q <= seen1_q | clr1_i;
      seen2_q <= seen2_q | clr2_i;
    end
  end
endmodule

// File: rtl/opt_wdt_chain.sv
module opt_wdt_chain #(
  parameter int PRE_W = 8,
  parameter int RIP_W = 7,
  parameter int TAP_N = 4,
  localparam int TAP_W = $clog2(TAP_N),
  localparam int CNT_W = PRE_W + RIP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cnt_o
);
  // lowest tap sits TAP_N bits below the ripple stage's top
  localparam int RIP_LO = RIP_W - TAP_N;

  logic [PRE_W-1:0] pre_q;
  logic [RIP_W-1:0] rip_q;
  logic             fin_q;
  logic             pre_cy;
  logic [TAP_N-1:0] tap_cy;
  logic             sel_cy;

  assign pre_cy = &pre_q;

  for (genvar k = 0; k < TAP_N; k++) begin : g_tap
    assign tap_cy[k] = pre_cy & (&rip_q[RIP_LO+k:0]);
  end

  assign sel_cy = tap_cy[tap_i];
  assign ovf_o  = en_i & tick_i & sel_cy & fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      rip_q <= '0;
      fin_q <= 1'b0;
    end else if (!en_i || clr_i || ovf_o) begin
      pre_q <= '0;
      rip_q <= '0;
      fin_q <= 1'b0;
    end else if (tick_i) begin
      pre_q <= pre_q + 1'b1;
      if (pre_cy) rip_q <= rip_q + 1'b1;
      if (sel_cy) fin_q <= ~fin_q;
    end
  end

  assign cnt_o = {fin_q, rip_q, pre_q};
endmodule

// File: rtl/opt_wdt.sv
module opt_wdt
  import opt_wdt_pkg::*;
#(
  parameter int PRE_W    = 8,
  parameter int RIP_W    = 7,
  parameter int TAP_N    = 4,
  parameter int INST_DIV = 4,
  localparam int TAP_W = $clog2(TAP_N),
  localparam int CNT_W = PRE_W + RIP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_sel_i,
  input  logic             osc_tick_i,
  input  logic [TAP_W-1:0] tap_sel_i,
  input  logic             wdt_en_i,
  input  logic             dual_clr_i,
  input  logic             clr_i,
  input  logic             clr1_i,
  input  logic             clr2_i,
  input  logic             halt_cmd_i,
  input  logic             halted_i,
  input  logic             to_clr_i,
  output logic             chip_rst_o,
  output logic             warm_rst_o,
  output logic             to_o
);
  logic             tick_w;
  logic             clr_w;
  logic             ovf_w;
  logic             ovf_ev;
  logic [CNT_W-1:0] cnt_w;
  logic             chip_q, warm_q, to_q;

  opt_wdt_tick_sel #(.INST_DIV(INST_DIV)) i_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (wdt_src_e'(src_sel_i)),
    .osc_tick_i(osc_tick_i),
    .halted_i  (halted_i),
    .tick_o    (tick_w)
  );

  opt_wdt_clr_ctl i_clr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (wdt_en_i),
    .mode_i    (wdt_clr_mode_e'(dual_clr_i)),
    .clr_i     (clr_i),
    .clr1_i    (clr1_i),
    .clr2_i    (clr2_i),
    .halt_cmd_i(halt_cmd_i),
    .ovf_i     (ovf_ev),
    .clr_o     (clr_w)
  );

  opt_wdt_chain #(.PRE_W(PRE_W), .RIP_W(RIP_W), .TAP_N(TAP_N)) i_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (wdt_en_i),
    .tick_i(tick_w),
    .clr_i (clr_w),
    .tap_i (tap_sel_i),
    .ovf_o (ovf_w),
    .cnt_o (cnt_w)
  );

  // a clear in the overflow cycle suppresses the request
  assign ovf_ev = ovf_w & ~clr_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_q <= 1'b0;
      warm_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      chip_q <= ovf_ev & ~halted_i;
      warm_q <= ovf_ev & halted_i;
      if (ovf_ev && !halted_i) to_q <= 1'b1;
      else if (to_clr_i)       to_q <= 1'b0;
    end
  end

  assign chip_rst_o = chip_q;
  assign warm_rst_o = warm_q;
  assign to_o       = to_q;
endmodule

// File: rtl/opt_wdt_chk.sv
module opt_wdt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wdt_en_i,
  input logic             halt_cmd_i,
  input logic             to_clr_i,
  input logic             chip_rst_o,
  input logic             warm_rst_o,
  input logic             to_o,
  input logic [CNT_W-1:0] cnt_i
);
  AST_CHIP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |=> !chip_rst_o);  // R4
  AST_TO_WITH_CHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_rst_o |-> to_o);  // R4
  AST_WARM_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_o |=> !warm_rst_o);  // R5
  AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chip_rst_o && warm_rst_o));  // R5
  AST_HALT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_en_i && halt_cmd_i) |=> (cnt_i == '0));  // R8
  AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_en_i |=> (cnt_i == '0) && !chip_rst_o && !warm_rst_o);  // R10
  AST_TO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_o && !to_clr_i) |=> to_o);  // R11
endmodule

bind opt_wdt opt_wdt_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wdt_en_i  (wdt_en_i),
  .halt_cmd_i(halt_cmd_i),
  .to_clr_i  (to_clr_i),
  .chip_rst_o(chip_rst_o),
  .warm_rst_o(warm_rst_o),
  .to_o      (to_o),
  .cnt_i     (cnt_w)
);

// File: tb/test_opt_wdt.sv
module test_opt_wdt;
  logic       clk_i      = 1'b0;
  logic       rst_ni     = 1'b0;
  logic       src_sel_i  = 1'b0;
  logic       osc_tick_i = 1'b1;
  logic [1:0] tap_sel_i  = 2'd0;
  logic       wdt_en_i   = 1'b1;
  logic       dual_clr_i = 1'b0;
  logic       clr_i      = 1'b0;
  logic       clr1_i     = 1'b0;
  logic       clr2_i     = 1'b0;
  logic       halt_cmd_i = 1'b0;
  logic       halted_i   = 1'b0;
  logic       to_clr_i   = 1'b0;
  logic       chip_rst_o, warm_rst_o, to_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  opt_wdt i_opt_wdt (.*);

  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic [1:0]  tap;
    logic        dual;
    logic        junk_one;
    logic        junk_pair;
    logic [31:0] per;
  } row_t;

  localparam row_t ROWS [3] = '{
    '{2'd0, 1'b0, 1'b0, 1'b1, 32'd8192},
    '{2'd1, 1'b1, 1'b1, 1'b0, 32'd16384},
    '{2'd2, 1'b0, 1'b0, 1'b0, 32'd32768}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R12 reset outputs", {29'd0, chip_rst_o, warm_rst_o, to_o}, 32'd0);
    rst_ni = 1'b1;
  endtask

  task automatic quiet(input int n, input string req);
    int hits = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (chip_rst_o || warm_rst_o) hits++;
    end
    chk(req, hits, 0);
  endtask

  task automatic expect_pulse(input bit chip_e, input bit warm_e, input string req);
    @(negedge clk_i);
    chk(req, {30'd0, chip_rst_o, warm_rst_o}, {30'd0, chip_e, warm_e});
    @(negedge clk_i);
    chk({req, " width"}, {30'd0, chip_rst_o, warm_rst_o}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // table: tap period and ignored strobes (R1 R2 R4 R6 R7 R11)
    for (int r = 0; r < 3; r++) begin
      tap_sel_i  = ROWS[r].tap;
      dual_clr_i = ROWS[r].dual;
      src_sel_i  = 1'b0;
      osc_tick_i = 1'b1;
      do_reset();
      quiet(99, "R1 early");
      clr_i  = ROWS[r].junk_one;
      clr1_i = ROWS[r].junk_pair;
      clr2_i = ROWS[r].junk_pair;
      @(negedge clk_i);
      clr_i  = 1'b0;
      clr1_i = 1'b0;
      clr2_i = 1'b0;
      quiet(int'(ROWS[r].per) - 101, "R6 R7 ignored strobe / R1 before period");
      expect_pulse(1'b1, 1'b0, "R1 R2 R4 chip pulse at period");
      chk("R4 to_o set", {31'd0, to_o}, 32'd1);
      rst_ni = 1'b0;
      @(negedge clk_i);
      chk("R11 to_o cleared by rst_ni", {31'd0, to_o}, 32'd0);
    end

    // R9 R6: clear on the overflowing edge wins, then full period
    tap_sel_i = 2'd0; dual_clr_i = 1'b0;
    do_reset();
    quiet(8191, "R9 before overflow");
    clr_i = 1'b1;
    @(negedge clk_i);
    chk("R9 clear beats overflow", {31'd0, chip_rst_o}, 32'd0);
    clr_i = 1'b0;
    quiet(8191, "R6 restart after clr_i");
    expect_pulse(1'b1, 1'b0, "R6 period after clr_i");

    // R7: repeated first command does not clear; overflow forgets it
    dual_clr_i = 1'b1;
    do_reset();
    quiet(9, "R7 lead");
    clr1_i = 1'b1; @(negedge clk_i); clr1_i = 1'b0;
    quiet(9, "R7 gap");
    clr1_i = 1'b1; @(negedge clk_i); clr1_i = 1'b0;
    quiet(8171, "R7 repeat no clear");
    expect_pulse(1'b1, 1'b0, "R7 overflow despite repeated clr1");
    to_clr_i = 1'b1; @(negedge clk_i); to_clr_i = 1'b0;
    chk("R11 to_clr_i clears to_o", {31'd0, to_o}, 32'd0);
    clr2_i = 1'b1; @(negedge clk_i); clr2_i = 1'b0;
    clr1_i = 1'b1; @(negedge clk_i); clr1_i = 1'b0;
    quiet(8191, "R7 pair in reverse order clears");
    expect_pulse(1'b1, 1'b0, "R7 period after pair");

    // R8 R5: halt instruction clears, halted overflow gives warm reset
    dual_clr_i = 1'b0; halted_i = 1'b1;
    do_reset();
    quiet(999, "R8 lead");
    halt_cmd_i = 1'b1; @(negedge clk_i); halt_cmd_i = 1'b0;
    quiet(8191, "R8 restart after halt_cmd_i");
    expect_pulse(1'b0, 1'b1, "R5 warm pulse");
    chk("R5 to_o unchanged", {31'd0, to_o}, 32'd0);
    halted_i = 1'b0;

    // R10: disabled
    wdt_en_i = 1'b0;
    do_reset();
    quiet(9000, "R10 no pulse when disabled");
    chk("R10 to_o stays low", {31'd0, to_o}, 32'd0);
    wdt_en_i = 1'b1;

    // R2 R3: instruction clock, frozen while halted
    src_sel_i = 1'b1; osc_tick_i = 1'b0;
    do_reset();
    quiet(16000, "R2 inst ticks early");
    halted_i = 1'b1;
    quiet(3000, "R3 halted no count");
    halted_i = 1'b0;
    quiet(16767, "R3 resumed count");
    expect_pulse(1'b1, 1'b0, "R2 R3 inst-clock overflow");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule